// File: doc/BRIEF.md
# Frame-Retrace Calibration Line Sequencer

This block sits behind a three-level sandcastle decoder in a video back end. It takes the decoded horizontal line pulse and the incoming vertical blanking level. From them it rebuilds a vertical blanking window of fixed length and drives the per-line control strobes that an automatic gun drive and cut-off loop needs during frame retrace. The analog side (comparators, hold capacitors, beam current limiting) is not part of the block. It only receives the timing produced here.

Counting begins on the rising edge of the incoming vertical blanking. Each rising edge of the line pulse then advances the line number. Lines 17 to 19 carry the drive-pulse inserts, line 20 the leakage sample, and lines 21 to 23 the quasi-cut-off inserts. The regenerated vertical window ends when the 24th line pulse arrives. If the incoming vertical blanking drops too early, the frame is abandoned and a fault flag is raised.

Top module: `vbseq_top`

## Requirements
- R1: While `rst_n` is low, every strobe output, `meas_sw_o` and `short_vb_o` are 0, and `comp_blank_o` follows `line_pulse_i` alone.
- R2: A rising edge on `vblank_i` starts the regenerated vertical window at line 0, and `comp_blank_o` is the OR of `line_pulse_i` and that window.
- R3: Each rising edge of `line_pulse_i` in the window advances the line number. The window covers lines 0 to 23 and closes on the next line pulse. It stays closed, whatever `line_pulse_i` and a falling `vblank_i` do, until the next rising edge of `vblank_i`.
- R4: `drive_en_o` bit 0 (green) is high for all of line 17, bit 1 (red) for line 18, and bit 2 (blue) for line 19, and is 0 otherwise.
- R5: `leak_strobe_o` is high for all of line 20 and only then.
- R6: `cutoff_en_o` bit 0 (green) is high for line 21, bit 1 (red) for line 22, and bit 2 (blue) for line 23, and is 0 otherwise.
- R7: `meas_sw_o` (1 = measurement resistor grounded) is high for lines 17 to 19 and low for lines 20 to 23 and outside the window.
- R8: At most one of the seven strobes (`drive_en_o`, `leak_strobe_o`, `cutoff_en_o`) is high in any cycle.
- R9: If `vblank_i` falls while the line number is below 11, the window closes one cycle later, no strobe appears for that frame, and `short_vb_o` goes high. It stays high until the next rising edge of `vblank_i`, which clears it.
- R10: A fall of `vblank_i` at line 11 or later has no effect. The window and its strobes run to the end.
- R11: A rising edge of `vblank_i` during a running window restarts it at line 0 and clears `short_vb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pulse_i | input | 1 | Decoded horizontal line pulse, level |
| vblank_i | input | 1 | Decoded incoming vertical blanking, level |
| comp_blank_o | output | 1 | Regenerated composite blanking |
| drive_en_o | output | 3 | Drive-pulse insert enables, bit 0 G, 1 R, 2 B |
| leak_strobe_o | output | 1 | Leakage-sample strobe |
| cutoff_en_o | output | 3 | Quasi-cut-off insert enables, bit 0 G, 1 R, 2 B |
| meas_sw_o | output | 1 | Measurement resistor to ground while high |
| short_vb_o | output | 1 | Incoming vertical blanking was too short |

## Verification
The assertions check the following on every cycle: strobe exclusivity, that the switch only closes together with a drive insert, that the fault keeps every strobe and the window quiet, that each strobe hands over to its successor on the next line pulse, and that the window opens on a blanking edge and closes after the last cut-off line. Only the bench scenarios can show the absolute line positions and the exact fault boundary at line 10 versus 11. They also cover the lack of effect of a late blanking fall, the restart mid-sequence, and the composite OR with the line pulse. The bench reaches these by counting the pulses it has sent itself.

// File: rtl/vbseq_pkg.sv
package vbseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  // true when a line number lies in the closed range [lo, hi]
  function automatic logic line_in(input int unsigned cnt,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

  // one-hot gun select for a line inside a three-line group starting at base
  function automatic logic [2:0] gun_sel(input int unsigned cnt,
                                         input int unsigned base);
    logic [2:0] r;
    r = 3'b000;
    for (int g = 0; g < 3; g++)
      if (cnt == base + g) r[g] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/vbseq_edge.sv
module vbseq_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = level_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~level_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/vbseq_counter.sv
module vbseq_counter
  import vbseq_pkg::*;
#(
  parameter int SEQ_LINES = 23,
  parameter int MIN_LINES = 11,
  parameter int CW        = $clog2(SEQ_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_rise,
  input  logic          v_fall,
  input  logic          h_rise,
  output logic [CW-1:0] line_cnt,
  output logic          running,
  output logic          fault,
  output logic          abort_evt,
  output logic          done_evt
);
  localparam logic [CW-1:0] LAST_LINE = CW'(SEQ_LINES);
  localparam logic [CW-1:0] MIN_CNT   = CW'(MIN_LINES);

  seq_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          fault_q;

  assign abort_evt = !v_rise && (state_q == SQ_RUN) && v_fall && (cnt_q < MIN_CNT);
  assign done_evt  = !v_rise && !abort_evt && (state_q == SQ_RUN) && h_rise
                     && (cnt_q == LAST_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (v_rise) begin
      state_q <= SQ_RUN;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (abort_evt) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      fault_q <= 1'b1;
    end else if (done_evt) begin
      state_q <= SQ_DONE;
    end else if ((state_q == SQ_RUN) && h_rise) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_cnt = cnt_q;
  assign running  = (state_q == SQ_RUN);
  assign fault    = fault_q;
endmodule

// File: rtl/vbseq_decoder.sv
module vbseq_decoder
  import vbseq_pkg::*;
#(
  parameter int FIRST_CAL_LINE = 17,
  parameter int CW             = 5
) (
  input  logic [CW-1:0] line_cnt,
  input  logic          running,
  output logic [2:0]    drive_en,
  output logic          leak_stb,
  output logic [2:0]    cutoff_en,
  output logic          meas_sw
);
  localparam int LEAK_LINE = FIRST_CAL_LINE + 3;
  localparam int CUT_BASE  = FIRST_CAL_LINE + 4;

  int unsigned cnt_u;
  assign cnt_u = int'(line_cnt);

  generate
    for (genvar g = 0; g < 3; g++) begin : g_gun
      assign drive_en[g]  = running && (cnt_u == FIRST_CAL_LINE + g);
      assign cutoff_en[g] = running && gun_sel(cnt_u, CUT_BASE)[g];
    end
  endgenerate

  assign leak_stb = running && (cnt_u == LEAK_LINE);
  assign meas_sw  = running && line_in(cnt_u, FIRST_CAL_LINE, FIRST_CAL_LINE + 2);
endmodule

// File: rtl/vbseq_top.sv
module vbseq_top #(
  parameter int FIRST_CAL_LINE = 17,
  parameter int SEQ_LINES      = FIRST_CAL_LINE + 6,
  parameter int MIN_LINES      = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_pulse_i,
  input  logic       vblank_i,
  output logic       comp_blank_o,
  output logic [2:0] drive_en_o,
  output logic       leak_strobe_o,
  output logic [2:0] cutoff_en_o,
  output logic       meas_sw_o,
  output logic       short_vb_o
);
  localparam int CW = $clog2(SEQ_LINES + 1);

  logic          h_rise, v_rise, v_fall;
  logic [CW-1:0] line_cnt;
  logic          running, abort_evt, done_evt;

  vbseq_edge #(.RISING(1'b1)) u_h_rise (
    .clk(clk), .rst_n(rst_n), .level_i(line_pulse_i), .edge_o(h_rise));
  vbseq_edge #(.RISING(1'b1)) u_v_rise (
    .clk(clk), .rst_n(rst_n), .level_i(vblank_i), .edge_o(v_rise));
  vbseq_edge #(.RISING(1'b0)) u_v_fall (
    .clk(clk), .rst_n(rst_n), .level_i(vblank_i), .edge_o(v_fall));

  vbseq_counter #(
    .SEQ_LINES(SEQ_LINES), .MIN_LINES(MIN_LINES), .CW(CW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .v_rise(v_rise), .v_fall(v_fall),
    .h_rise(h_rise), .line_cnt(line_cnt), .running(running),
    .fault(short_vb_o), .abort_evt(abort_evt), .done_evt(done_evt));

  vbseq_decoder #(
    .FIRST_CAL_LINE(FIRST_CAL_LINE), .CW(CW)
  ) u_dec (
    .line_cnt(line_cnt), .running(running), .drive_en(drive_en_o),
    .leak_stb(leak_strobe_o), .cutoff_en(cutoff_en_o), .meas_sw(meas_sw_o));

  assign comp_blank_o = line_pulse_i | running;
endmodule

// File: rtl/vbseq_chk.sv
module vbseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_rise,
  input logic       v_rise,
  input logic       running,
  input logic       abort_evt,
  input logic       done_evt,
  input logic [2:0] drive_en_o,
  input logic       leak_strobe_o,
  input logic [2:0] cutoff_en_o,
  input logic       meas_sw_o,
  input logic       short_vb_o
);
  // R8: never two strobes together
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_en_o, leak_strobe_o, cutoff_en_o}));

  // R7: resistor switch closes only alongside a drive insert
  a_r7_switch_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    meas_sw_o |-> ((|drive_en_o) && !leak_strobe_o && !(|cutoff_en_o)));

  // R4: drive order green then red then blue
  a_r4_green_to_red: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o[0] && h_rise && !v_rise) |=> drive_en_o[1]);
  a_r4_red_to_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o[1] && h_rise && !v_rise) |=> drive_en_o[2]);

  // R5/R6: leakage line hands over to green cut-off
  a_r6_leak_to_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_strobe_o && h_rise && !v_rise) |=> cutoff_en_o[0]);

  // R9: fault keeps everything quiet
  a_r9_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    short_vb_o |-> (!running && !meas_sw_o && !leak_strobe_o
                    && !(|drive_en_o) && !(|cutoff_en_o)));
  a_r9_abort_raises: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (short_vb_o && !running));

  // R2/R11: blanking edge opens the window
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    v_rise |=> (running && !short_vb_o));

  // R3: window closes after the blue cut-off line
  a_r3_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cutoff_en_o[2] && h_rise && !v_rise) |=> !running);
  a_r3_done_evt: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> cutoff_en_o[2]);
endmodule

bind vbseq_top vbseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_rise(h_rise), .v_rise(v_rise),
  .running(running), .abort_evt(abort_evt), .done_evt(done_evt),
  .drive_en_o(drive_en_o), .leak_strobe_o(leak_strobe_o),
  .cutoff_en_o(cutoff_en_o), .meas_sw_o(meas_sw_o), .short_vb_o(short_vb_o));

// File: tb/vbseq_top_tb_top.sv
module vbseq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hp = 1'b0;
  logic vb = 1'b0;
  logic comp_blank, leak, msw, fault;
  logic [2:0] drv, cut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int  ln = 0;
  bit  seq_on = 1'b0;
  bit  fault_m = 1'b0;

  always #10 clk = ~clk;

  vbseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .line_pulse_i(hp), .vblank_i(vb),
    .comp_blank_o(comp_blank), .drive_en_o(drv), .leak_strobe_o(leak),
    .cutoff_en_o(cut), .meas_sw_o(msw), .short_vb_o(fault));

  function automatic bit run_m();
    return seq_on && (ln <= 23);
  endfunction

  function automatic logic [2:0] exp_drive(int l);
    if (l >= 17 && l <= 19) return 3'b001 << (l - 17);
    return 3'b000;
  endfunction

  function automatic logic [2:0] exp_cut(int l);
    if (l >= 21 && l <= 23) return 3'b001 << (l - 21);
    return 3'b000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s line=%0d actual=%0h expected=%0h", req, ln, act, exp);
    end
  endtask

  task automatic check_strobes();
    bit r;
    r = run_m();
    check("R4 drive", {29'd0, drv}, {29'd0, r ? exp_drive(ln) : 3'b000});
    check("R5 leak", {31'd0, leak}, {31'd0, r && (ln == 20)});
    check("R6 cutoff", {29'd0, cut}, {29'd0, r ? exp_cut(ln) : 3'b000});
    check("R7 switch", {31'd0, msw}, {31'd0, r && ln >= 17 && ln <= 19});
    check("R8 single", {31'd0, ($countones({drv, leak, cut}) <= 1)}, 32'd1);
    check("R9 fault", {31'd0, fault}, {31'd0, fault_m});
  endtask

  task automatic send_line(input int low_len);
    hp = 1'b1;
    @(negedge clk);
    if (seq_on) ln++;
    check_strobes();
    check("R2 comp during pulse", {31'd0, comp_blank}, 32'd1);
    @(negedge clk);
    hp = 1'b0;
    @(negedge clk);
    check("R3 window", {31'd0, comp_blank}, {31'd0, run_m()});
    repeat (low_len) @(negedge clk);
  endtask

  task automatic vb_rise();
    vb = 1'b1;
    @(negedge clk);
    ln = 0; seq_on = 1'b1; fault_m = 1'b0;
    check("R11 restart window", {31'd0, comp_blank}, 32'd1);
    check_strobes();
  endtask

  task automatic vb_fall();
    vb = 1'b0;
    @(negedge clk);
    if (run_m() && ln < 11) begin
      seq_on = 1'b0;
      fault_m = 1'b1;
    end
    check("R10 late fall", {31'd0, comp_blank}, {31'd0, run_m()});
    check_strobes();
  endtask

  task automatic frame(input int vb_lines, input int restart_at);
    vb_rise();
    if (vb_lines == 0) vb_fall();
    for (int i = 1; i <= 26; i++) begin
      send_line($urandom_range(3, 7));
      if (vb && ln == vb_lines && seq_on) vb_fall();
      if (restart_at != 0 && i == restart_at) begin
        if (vb) vb_fall();
        vb_rise();
      end
    end
    if (vb) vb_fall();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drive", {29'd0, drv}, 32'd0);
    check("R1 leak", {31'd0, leak}, 32'd0);
    check("R1 cut", {29'd0, cut}, 32'd0);
    check("R1 switch", {31'd0, msw}, 32'd0);
    check("R1 fault", {31'd0, fault}, 32'd0);
    check("R1 comp", {31'd0, comp_blank}, 32'd0);
    hp = 1'b1;
    @(negedge clk);
    check("R1 comp follows pulse", {31'd0, comp_blank}, 32'd1);
    hp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frame(12, 0);   // R10 normal frame
    frame(11, 0);   // R10 boundary: line 11 accepted
    frame(10, 0);   // R9 boundary: line 10 aborts
    frame(0, 0);    // R9 fall before any line
    frame(20, 0);   // R10 fall on the leakage line
    frame(26, 0);   // R3 blanking held past the window
    frame(12, 18);  // R11 restart mid drive sequence
    frame(5, 0);    // R9 then R11 clears fault on next frame
    for (int k = 0; k < 8; k++)
      frame($urandom_range(4, 26), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule